// File: doc/BRIEF.md
# Sliding Aperture Translator

This block sits on a simple register bus and turns a fixed 1MB region of that register space into a movable view of a 40-bit device memory. A single control word places the view: a base index counted in 64KB steps, and a two-bit code naming which memory space the access should go to. Because the view is 1MB wide but moves in 64KB steps, neighbouring placements overlap.

Every accepted access that lands in the 1MB region is translated into a 40-bit device address and issued downstream as a memory request. That request carries the space code and the original write data and byte strobes. Accesses to the control word are served locally with a one-cycle response. Accesses that hit neither are left unclaimed and flagged so that other decoders on the same bus can take them. Translations that name the reserved space code, or that would run past the top of the 40-bit space, are refused with an error response instead of being issued.

Top module: `sliding_aperture`

## Requirements
- R1: After reset the control word is zero, so a region access at offset X is issued with device address X and space code 0.
- R2: Register addresses 0x700000 to 0x7FFFFF are claimed as region accesses. Any address that is neither in this range nor the control word raises `pass_valid` while `req_valid` is high, keeps `req_ready` low and issues nothing downstream.
- R3: A region access is issued with `mem_addr` = (base << 16) + (req_addr & 0xFFFFF) and with `mem_target` equal to the stored space code.
- R4: The control word keeps the base in bits 23:0 and the space code in bits 25:24. Each byte is written only when its strobe bit is set. Bits 31:26 ignore writes and read back as zero. A read returns the stored word in `rsp_rdata`.
- R5: Space codes are 0 local video memory, 1 coherent system memory and 2 non-coherent system memory. Code 3 is reserved: a region access made while it is stored is not issued and gets a response with `rsp_err` = 1.
- R6: If (base << 16) + offset exceeds 0xFF_FFFF_FFFF, the access is not issued and gets a response with `rsp_err` = 1. The highest address, 0xFF_FFFF_FFFF, is still issued.
- R7: A control write is used by the first region access accepted after it. A request already waiting downstream keeps the address and code it was issued with.
- R8: An accepted access produces its downstream request or its response in the next cycle. `mem_valid` and its fields stay stable until `mem_ready` is high, and `req_ready` is low while a request is waiting.
- R9: The control word sits at word address 0x001700. Byte address bits 1:0 are ignored, so 0x001702 also hits it, while 0x001704 does not. Its responses carry `rsp_err` = 0, and a write response returns zero data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle (claimed and not stalled) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 24 | Register-space byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes |
| pass_valid | output | 1 | Request not claimed by this block |
| rsp_valid | output | 1 | Local response (control access or refused region access) |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Control read data |
| mem_valid | output | 1 | Downstream request present |
| mem_ready | input | 1 | Downstream accepts the request |
| mem_write | output | 1 | Downstream write |
| mem_addr | output | 40 | Translated device address |
| mem_target | output | 2 | Memory space code |
| mem_wdata | output | 32 | Downstream write data |
| mem_strb | output | 4 | Downstream byte strobes |

## Verification
Translation is tried at the bottom and top offsets of the region and at several bases, including the reset base and bases near the top of the 40-bit space. This separates a correct shift-and-add from a wrapped result or one that drops offset bits. Addresses just outside both ends of the region and next to the control word show whether decode is exact. Partial-strobe writes and writes to the unused bits show which byte lanes the control word takes. Finally, a stalled downstream request with a control write queued behind it shows that the pending request keeps its translation and that the new one waits for the next access.

// File: rtl/aperture_pkg.sv
// Shared types and fixed field positions for the sliding aperture.
// Assumes a 32-bit control word with base in the low bits and space code above it.
package aperture_pkg;
    localparam int CTRL_W  = 32;
    localparam int TGT_W   = 2;

    typedef enum logic [TGT_W-1:0] {
        SPACE_VIDMEM  = 2'd0,
        SPACE_COH     = 2'd1,
        SPACE_NONCOH  = 2'd2,
        SPACE_RSVD    = 2'd3
    } space_e;
endpackage

// File: rtl/aperture_decode.sv
// Address decoder: tells region hits from control-word hits and extracts the
// in-region offset. Assumes the region is aligned to its own size and the
// control word lies outside it.
module aperture_decode #(
    parameter int                REG_AW    = 24,
    parameter int                WIN_BITS  = 20,
    parameter logic [REG_AW-1:0] WIN_START = 24'h700000,
    parameter logic [REG_AW-1:0] CTRL_ADDR = 24'h001700
) (
    input  logic [REG_AW-1:0]   addr,
    output logic                win_hit,
    output logic                ctrl_hit,
    output logic [WIN_BITS-1:0] win_off
);
    localparam int UPPER_W = REG_AW - WIN_BITS;

    // Compare the upper bits for the region and the word address for the control word.
    always_comb begin
        win_hit  = (addr[REG_AW-1:WIN_BITS] == WIN_START[REG_AW-1:WIN_BITS]);
        ctrl_hit = (addr[REG_AW-1:2] == CTRL_ADDR[REG_AW-1:2]);
        win_off  = addr[WIN_BITS-1:0];
    end

    // Region must hold whole words and the upper compare must have width.
    initial begin
        if (UPPER_W < 1) $error("aperture_decode: region wider than register space");
    end
endmodule

// File: rtl/aperture_ctrl_reg.sv
// Control word storage with byte-strobe writes. Unused upper bits are never
// stored. Assumes a 32-bit word split into byte lanes.
module aperture_ctrl_reg #(
    parameter int BASE_W = 24,
    parameter int TGT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [31:0]             wdata,
    input  logic [3:0]              strb,
    output logic [BASE_W-1:0]       base,
    output logic [TGT_W-1:0]        tgt,
    output logic [31:0]             rd_word
);
    localparam int          USED_W = BASE_W + TGT_W;
    localparam logic [31:0] KEEP   = 32'((64'd1 << USED_W) - 64'd1);

    logic [31:0] word_q;

    for (genvar b = 0; b < 4; b++) begin : g_lane
        // Update one byte lane when it is strobed, dropping unused bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[8*b +: 8] <= 8'h00;
            else if (wr_en && strb[b])
                word_q[8*b +: 8] <= wdata[8*b +: 8] & KEEP[8*b +: 8];
        end
    end

    // Split the stored word into its fields.
    always_comb begin
        base    = word_q[BASE_W-1:0];
        tgt     = word_q[USED_W-1:BASE_W];
        rd_word = word_q;
    end
endmodule

// File: rtl/aperture_xlate.sv
// Translator: forms the device address from base and offset and flags a
// reserved space code or an address past the top of device memory.
module aperture_xlate #(
    parameter int DEV_AW    = 40,
    parameter int STEP_BITS = 16,
    parameter int WIN_BITS  = 20,
    parameter int TGT_W     = 2
) (
    input  logic [DEV_AW-STEP_BITS-1:0] base,
    input  logic [TGT_W-1:0]            tgt,
    input  logic [WIN_BITS-1:0]         off,
    output logic [DEV_AW-1:0]           dev_addr,
    output logic                        err
);
    import aperture_pkg::*;

    logic [DEV_AW:0] sum;

    // Add with one spare bit so overflow is seen rather than wrapped.
    always_comb begin
        sum      = {1'b0, base, {STEP_BITS{1'b0}}} + (DEV_AW+1)'(off);
        dev_addr = sum[DEV_AW-1:0];
        err      = sum[DEV_AW] || (tgt == SPACE_RSVD);
    end
endmodule

// File: rtl/sliding_aperture.sv
// Top: accepts register-bus requests, serves the control word, and issues
// translated region accesses downstream with a space code. Holds one
// downstream request at a time and stalls the bus while it waits.
module sliding_aperture #(
    parameter int                REG_AW    = 24,
    parameter int                DEV_AW    = 40,
    parameter int                WIN_BITS  = 20,
    parameter int                STEP_BITS = 16,
    parameter int                DATA_W    = 32,
    parameter logic [REG_AW-1:0] WIN_START = 24'h700000,
    parameter logic [REG_AW-1:0] CTRL_ADDR = 24'h001700
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [REG_AW-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_strb,
    output logic                  pass_valid,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic                  mem_write,
    output logic [DEV_AW-1:0]     mem_addr,
    output logic [1:0]            mem_target,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W/8-1:0]   mem_strb
);
    import aperture_pkg::*;

    localparam int BASE_W = DEV_AW - STEP_BITS;

    logic                win_hit, ctrl_hit, claim, acc, ctrl_wr;
    logic [WIN_BITS-1:0] win_off;
    logic [BASE_W-1:0]   base;
    logic [TGT_W-1:0]    tgt;
    logic [31:0]         rd_word;
    logic [DEV_AW-1:0]   dev_addr;
    logic                xl_err;

    aperture_decode #(
        .REG_AW(REG_AW), .WIN_BITS(WIN_BITS),
        .WIN_START(WIN_START), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr(req_addr), .win_hit(win_hit), .ctrl_hit(ctrl_hit), .win_off(win_off)
    );

    aperture_ctrl_reg #(.BASE_W(BASE_W), .TGT_W(TGT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr),
        .wdata(req_wdata[31:0]), .strb(req_strb[3:0]),
        .base(base), .tgt(tgt), .rd_word(rd_word)
    );

    aperture_xlate #(
        .DEV_AW(DEV_AW), .STEP_BITS(STEP_BITS), .WIN_BITS(WIN_BITS), .TGT_W(TGT_W)
    ) u_xl (
        .base(base), .tgt(tgt), .off(win_off), .dev_addr(dev_addr), .err(xl_err)
    );

    // Claim decode, stall while a downstream request waits, and acceptance.
    always_comb begin
        claim      = win_hit || ctrl_hit;
        req_ready  = claim && !mem_valid;
        acc        = req_valid && req_ready;
        ctrl_wr    = acc && ctrl_hit && req_write;
        pass_valid = req_valid && !claim;
    end

    // Local response for control accesses and refused region accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc && (ctrl_hit || xl_err);
            rsp_err   <= acc && win_hit && xl_err;
            rsp_rdata <= (acc && ctrl_hit && !req_write) ? DATA_W'(rd_word) : '0;
        end
    end

    // Downstream request register: load on a good region access, drop on ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid  <= 1'b0;
            mem_write  <= 1'b0;
            mem_addr   <= '0;
            mem_target <= '0;
            mem_wdata  <= '0;
            mem_strb   <= '0;
        end else if (acc && win_hit && !xl_err) begin
            mem_valid  <= 1'b1;
            mem_write  <= req_write;
            mem_addr   <= dev_addr;
            mem_target <= tgt;
            mem_wdata  <= req_wdata;
            mem_strb   <= req_strb;
        end else if (mem_ready) begin
            mem_valid  <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_target)); // R8
    AST_STALL_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready); // R8
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> mem_addr[STEP_BITS-1:0] == $past(req_addr[STEP_BITS-1:0])); // R3
    AST_NO_RSVD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_target != SPACE_RSVD); // R5
    AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> !mem_valid); // R6
    AST_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> !req_ready); // R2
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_rdata[31:26] == 6'd0); // R4
endmodule

// File: tb/sim_sliding_aperture.sv
// Bench: behavioural reference model updated on each rising edge and compared
// with every output shortly after each falling edge.
module sim_sliding_aperture;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic        mem_ready = 1'b1;
    logic        req_ready, pass_valid, rsp_valid, rsp_err, mem_valid, mem_write;
    logic [31:0] rsp_rdata, mem_wdata;
    logic [39:0] mem_addr;
    logic [1:0]  mem_target;
    logic [3:0]  mem_strb;

    sliding_aperture u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_strb(req_strb), .pass_valid(pass_valid), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_target(mem_target), .mem_wdata(mem_wdata), .mem_strb(mem_strb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0, n_fails = 0, cycles = 0;
    string tag = "R1";

    // Reference model state.
    longint m_word = 0;
    bit     m_mv = 0, m_mw = 0, m_rv = 0, m_re = 0;
    longint m_ma = 0, m_rd = 0, m_wd = 0;
    int     m_mt = 0, m_ms = 0;

    function automatic bit is_win(input logic [23:0] a);
        return (a >= 24'h700000) && (a <= 24'h7FFFFF);
    endfunction
    function automatic bit is_ctrl(input logic [23:0] a);
        return (a >> 2) == (24'h001700 >> 2);
    endfunction

    task automatic chk(input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Reference model: next state from the inputs seen at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = 0; m_mv = 0; m_rv = 0; m_re = 0; m_rd = 0;
        end else begin
            bit claim, acc;
            longint base, off, a;
            int sp;
            claim = is_win(req_addr) || is_ctrl(req_addr);
            acc   = req_valid && claim && !m_mv;
            if (m_mv && mem_ready) m_mv = 0;
            m_rv = 0; m_re = 0; m_rd = 0;
            if (acc && is_ctrl(req_addr)) begin
                m_rv = 1;
                if (req_write) begin
                    for (int b = 0; b < 4; b++)
                        if (req_strb[b])
                            m_word = (m_word & ~(longint'(8'hFF) << (8*b)))
                                   | (longint'(req_wdata[8*b +: 8]) << (8*b));
                    m_word = m_word & 64'h03FF_FFFF;
                end else m_rd = m_word;
            end else if (acc) begin
                base = m_word & 64'hFF_FFFF;
                sp   = int'((m_word >> 24) & 3);
                off  = longint'(req_addr) & 64'hF_FFFF;
                a    = base * 65536 + off;
                if (sp == 3 || a > 64'hFF_FFFF_FFFF) begin
                    m_rv = 1; m_re = 1;
                end else begin
                    m_mv = 1; m_ma = a; m_mt = sp; m_mw = req_write;
                    m_wd = longint'(req_wdata); m_ms = int'(req_strb);
                end
            end
        end
    end

    // Compare every output with the model after the falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit claim;
            claim = is_win(req_addr) || is_ctrl(req_addr);
            chk("req_ready", longint'(req_ready), longint'(claim && !m_mv));
            chk("pass_valid", longint'(pass_valid), longint'(req_valid && !claim));
            chk("mem_valid", longint'(mem_valid), longint'(m_mv));
            if (m_mv) begin
                chk("mem_addr", longint'(mem_addr), m_ma);
                chk("mem_target", longint'(mem_target), longint'(m_mt));
                chk("mem_write", longint'(mem_write), longint'(m_mw));
                chk("mem_wdata", longint'(mem_wdata), m_wd);
                chk("mem_strb", longint'(mem_strb), longint'(m_ms));
            end
            chk("rsp_valid", longint'(rsp_valid), longint'(m_rv));
            if (m_rv) begin
                chk("rsp_err", longint'(rsp_err), longint'(m_re));
                chk("rsp_rdata", longint'(rsp_rdata), m_rd);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            finish_run();
        end
    end

    // One bus access; waits for acceptance when the address is claimed.
    task automatic access(input bit wr, input logic [23:0] a, input logic [31:0] d,
                          input logic [3:0] s);
        bit r;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
        if (!(is_win(a) || is_ctrl(a))) begin
            @(negedge clk);
        end else begin
            forever begin
                #1 r = req_ready;
                @(posedge clk);
                if (r) break;
                @(negedge clk);
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        access(0, 24'h001700, 0, 4'hF);
        access(1, 24'h712345, 32'hCAFE0001, 4'h3);
        tag = "R4";
        access(1, 24'h001700, 32'hFE00_1234, 4'hF);
        access(0, 24'h001700, 0, 4'hF);
        access(1, 24'h001700, 32'h01AB_0000, 4'h4);
        access(0, 24'h001700, 0, 4'hF);
        access(1, 24'h001700, 32'h0100_0000, 4'h8);
        access(0, 24'h001700, 0, 4'hF);
        tag = "R3";
        access(0, 24'h7FFFFF, 0, 4'hF);
        access(1, 24'h700000, 32'h5A5A_5A5A, 4'h9);
        access(1, 24'h001700, 32'h0212_3400, 4'hF);
        access(0, 24'h7ABCDE, 0, 4'hF);
        tag = "R2";
        access(0, 24'h6FFFFF, 0, 4'hF);
        access(1, 24'h800000, 32'h1, 4'hF);
        access(0, 24'h000000, 0, 4'hF);
        access(0, 24'h700000, 0, 4'hF);
        tag = "R9";
        access(0, 24'h001702, 0, 4'hF);
        access(0, 24'h001704, 0, 4'hF);
        access(1, 24'h0016FC, 32'hFFFF_FFFF, 4'hF);
        access(0, 24'h001700, 0, 4'hF);
        tag = "R5";
        access(1, 24'h001700, 32'h0300_0010, 4'hF);
        access(1, 24'h700020, 32'h77, 4'hF);
        access(0, 24'h7FFFFF, 0, 4'hF);
        tag = "R6";
        access(1, 24'h001700, 32'h00FF_FFFF, 4'hF);
        access(0, 24'h70FFFF, 0, 4'hF);
        access(0, 24'h710000, 0, 4'hF);
        access(1, 24'h001700, 32'h00FF_FFF0, 4'hF);
        access(0, 24'h7FFFFF, 0, 4'hF);
        access(1, 24'h001700, 32'h01FF_FFF1, 4'hF);
        access(0, 24'h7FFFFF, 0, 4'hF);
        tag = "R7";
        access(1, 24'h001700, 32'h0000_0042, 4'hF);
        @(negedge clk); mem_ready = 1'b0;
        access(1, 24'h700010, 32'hAAAA_5555, 4'hF);
        tag = "R8";
        fork
            access(1, 24'h001700, 32'h0100_0099, 4'hF);
            begin repeat (5) @(negedge clk); mem_ready = 1'b1; end
        join
        tag = "R7";
        access(0, 24'h700010, 0, 4'hF);
        access(0, 24'h001700, 0, 4'hF);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule